// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block holds five alarm registers (seconds, minutes, hours, weekday and date) and compares them with the live BCD time supplied by an external timekeeping counter. The comparison is made only on cycles that carry the once-per-second tick. When every field that takes part in the comparison equals its live counterpart, the block raises an alarm flag. If the alarm interrupt is enabled, it also drives an interrupt pin.

Each alarm register keeps a mask in its top bit. A field with the mask set drops out of the comparison, so the alarm can fire on one exact second of one date or once every minute. The registers can only be written while a write-unlock level input is high. The host clears the flag by strobing a flags read. The interrupt pin either holds its state until that read (level mode) or returns to idle after a fixed number of 32 Hz timebase ticks (pulse mode). Its active polarity can be selected.

Top module: `bcd_alarm_unit`

## Requirements
- R1: After reset all five alarm registers hold 0x00, `alarm_flag` is 0 and the interrupt is inactive, so `irq_pin` equals the inverse of `irq_act_high`.
- R2: A write takes effect on the clock edge where `reg_wr` and `wr_unlock` are both 1. `reg_sel` picks the field: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date. A write with `reg_sel` of 5 to 7 changes no register.
- R3: A write strobe while `wr_unlock` is 0 leaves every alarm register unchanged.
- R4: Bit 7 of an alarm register is its mask. When it is 1 the field is excluded from the comparison. When it is 0, bits 6:0 of the register must equal bits 6:0 of the live field. The live field i sits at `live_time[8*i+7:8*i]`, with i numbered as in R2.
- R5: `alarm_flag` becomes 1 in the cycle after an edge where `sec_tick` is 1 and every unmasked field matches. A match without `sec_tick` does nothing.
- R6: `flags_rd` clears `alarm_flag` in the next cycle. If a new match event happens in the same cycle as the read, the flag stays 1.
- R7: A match event asserts the interrupt only when `irq_en` is 1 in that cycle. With `irq_en` at 0 the flag is still set.
- R8: In level mode (`irq_pulse` = 0) the interrupt stays asserted until `flags_rd`, whatever happens on `tick32`.
- R9: In pulse mode the interrupt is released on the PULSE_TICKS-th `tick32` after the event (default 6, about 190 ms), or earlier on `flags_rd`.
- R10: `irq_pin` is high while the interrupt is active when `irq_act_high` is 1, and low while it is active when `irq_act_high` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_unlock | input | 1 | Write-unlock bit; alarm registers are writable only while 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Alarm field select |
| reg_wdata | input | 8 | Write data: bit 7 mask, bits 6:0 BCD value |
| flags_rd | input | 1 | Flags read strobe; clears the flag and the interrupt |
| live_time | input | 40 | Live BCD time, five 8-bit fields |
| sec_tick | input | 1 | One-cycle qualifier, once per second |
| tick32 | input | 1 | One-cycle qualifier from the 32 Hz timebase |
| irq_en | input | 1 | Alarm interrupt enable |
| irq_pulse | input | 1 | 1: pulse mode, 0: level mode |
| irq_act_high | input | 1 | Interrupt pin polarity, 1 is active high |
| alarm_flag | output | 1 | Alarm flag |
| irq_pin | output | 1 | Interrupt pin |

## Verification
The assertions assume that `sec_tick` and `tick32` are single-cycle qualifiers and that the configuration inputs are driven synchronously to `clk`. They also assume the time counter moves the live time only between ticks. The stimulus changes every input one nanosecond after the rising edge and holds it for a full cycle. The random phase sets each live field equal to its alarm value half of the time, so match events, simultaneous reads and pulse timeouts all occur often.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int ALM_FIELDS  = 5;
    localparam int ALM_FIELD_W = 8;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_WDAY  = 3'd3,
        FLD_DATE  = 3'd4
    } alm_field_e;
endpackage

// File: rtl/alm_regs.sv
module alm_regs #(
    parameter int N     = 5,
    parameter int W     = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_unlock,
    input  logic             wr_stb,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    output logic [N*W-1:0]   regs_o
);
    logic [N-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < N; i++) begin
            if (wr_stb && wr_unlock && (int'(wr_sel) == i)) begin
                regs_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;

    assert_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_unlock) |=> $stable(regs_q));
endmodule

// File: rtl/alm_cmp.sv
module alm_cmp #(
    parameter int N = 5,
    parameter int W = 8
) (
    input  logic [N*W-1:0] alarm_regs,
    input  logic [N*W-1:0] live,
    output logic           all_hit
);
    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_field
        logic [W-1:0] a_f, l_f;
        assign a_f = alarm_regs[g*W +: W];
        assign l_f = live[g*W +: W];
        assign hit[g] = a_f[W-1] || (a_f[W-2:0] == l_f[W-2:0]);
    end

    assign all_hit = &hit;
endmodule

// File: rtl/alm_irq.sv
module alm_irq #(
    parameter int PULSE_TICKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd_stb,
    input  logic tick32,
    input  logic irq_en,
    input  logic pulse_mode,
    input  logic act_high,
    output logic flag,
    output logic pin
);
    localparam int CNT_W = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic             flag;
        logic             active;
        logic [CNT_W-1:0] cnt;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt) st_d.flag = 1'b1;
        else if (rd_stb) st_d.flag = 1'b0;

        if (evt && irq_en) begin
            st_d.active = 1'b1;
            st_d.cnt    = CNT_W'(PULSE_TICKS);
        end else if (st_q.active) begin
            if (rd_stb) begin
                st_d.active = 1'b0;
            end else if (pulse_mode && tick32) begin
                if (st_q.cnt <= CNT_W'(1)) st_d.active = 1'b0;
                else st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign pin  = act_high ? st_q.active : ~st_q.active;

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !evt) |=> !flag);
    assert_level_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !pulse_mode && !rd_stb) |=> st_q.active);
    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> $past(irq_en && evt));
    assert_pulse_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(PULSE_TICKS));
endmodule

// File: rtl/bcd_alarm_unit.sv
module bcd_alarm_unit #(
    parameter int NUM_FIELDS  = alm_pkg::ALM_FIELDS,
    parameter int FIELD_W     = alm_pkg::ALM_FIELD_W,
    parameter int PULSE_TICKS = 6,
    parameter int SEL_W       = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_unlock,
    input  logic                          reg_wr,
    input  logic [SEL_W-1:0]              reg_sel,
    input  logic [FIELD_W-1:0]            reg_wdata,
    input  logic                          flags_rd,
    input  logic [NUM_FIELDS*FIELD_W-1:0] live_time,
    input  logic                          sec_tick,
    input  logic                          tick32,
    input  logic                          irq_en,
    input  logic                          irq_pulse,
    input  logic                          irq_act_high,
    output logic                          alarm_flag,
    output logic                          irq_pin
);
    localparam int BUS_W = NUM_FIELDS * FIELD_W;

    logic [BUS_W-1:0] alarm_regs;
    logic             all_hit;
    logic             match_evt;

    alm_regs #(.N(NUM_FIELDS), .W(FIELD_W), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_unlock (wr_unlock),
        .wr_stb    (reg_wr),
        .wr_sel    (reg_sel),
        .wr_data   (reg_wdata),
        .regs_o    (alarm_regs)
    );

    alm_cmp #(.N(NUM_FIELDS), .W(FIELD_W)) u_cmp (
        .alarm_regs (alarm_regs),
        .live       (live_time),
        .all_hit    (all_hit)
    );

    assign match_evt = sec_tick && all_hit;

    alm_irq #(.PULSE_TICKS(PULSE_TICKS)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (match_evt),
        .rd_stb     (flags_rd),
        .tick32     (tick32),
        .irq_en     (irq_en),
        .pulse_mode (irq_pulse),
        .act_high   (irq_act_high),
        .flag       (alarm_flag),
        .pin        (irq_pin)
    );

    assert_flag_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(sec_tick));
endmodule

// File: tb/bcd_alarm_unit_test.sv
module bcd_alarm_unit_test;
    localparam int NF = 5;
    localparam int PT = 6;

    logic clk = 0;
    logic rst_n = 0;
    logic wr_unlock = 0, reg_wr = 0, flags_rd = 0, sec_tick = 0, tick32 = 0;
    logic irq_en = 0, irq_pulse = 0, irq_act_high = 1;
    logic [2:0] reg_sel = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] live_f [NF];
    logic [NF*8-1:0] live_time;
    logic alarm_flag, irq_pin;

    int checks = 0, errors = 0;
    logic [7:0] regs_m [NF];
    bit flag_m, act_m;
    int cnt_m;

    always #10 clk = ~clk;

    always_comb for (int i = 0; i < NF; i++) live_time[i*8 +: 8] = live_f[i];

    bcd_alarm_unit #(.PULSE_TICKS(PT)) uut (
        .clk(clk), .rst_n(rst_n), .wr_unlock(wr_unlock), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .flags_rd(flags_rd),
        .live_time(live_time), .sec_tick(sec_tick), .tick32(tick32),
        .irq_en(irq_en), .irq_pulse(irq_pulse), .irq_act_high(irq_act_high),
        .alarm_flag(alarm_flag), .irq_pin(irq_pin)
    );

    function automatic bit model_match();
        for (int i = 0; i < NF; i++)
            if (!regs_m[i][7] && regs_m[i][6:0] != live_f[i][6:0]) return 0;
        return 1;
    endfunction

    function automatic bit exp_pin();
        return irq_act_high ? act_m : !act_m;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input string req);
        bit evt;
        evt = sec_tick && model_match();
        @(posedge clk);
        #1;
        if (evt) flag_m = 1; else if (flags_rd) flag_m = 0;
        if (evt && irq_en) begin act_m = 1; cnt_m = PT; end
        else if (act_m) begin
            if (flags_rd) act_m = 0;
            else if (irq_pulse && tick32) begin
                if (cnt_m <= 1) act_m = 0; else cnt_m--;
            end
        end
        if (reg_wr && wr_unlock && reg_sel < NF) regs_m[reg_sel] = reg_wdata;
        chk(req, "alarm_flag", alarm_flag, flag_m);
        chk(req, "irq_pin", irq_pin, exp_pin());
        reg_wr = 0; flags_rd = 0; sec_tick = 0; tick32 = 0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d, input logic unl, input string req);
        wr_unlock = unl; reg_wr = 1; reg_sel = s; reg_wdata = d;
        step(req);
        wr_unlock = 0;
    endtask

    task automatic set_live(input logic [7:0] s, input logic [7:0] m);
        live_f[0] = s; live_f[1] = m;
    endtask

    task automatic tick(input string req);
        sec_tick = 1; step(req);
    endtask

    task automatic rd(input string req);
        flags_rd = 1; step(req);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NF; i++) begin live_f[i] = 8'h01; regs_m[i] = 0; end
        flag_m = 0; act_m = 0; cnt_m = 0;
        void'($urandom(32'd4242));
        #45;
        // R1: reset state
        chk("R1", "alarm_flag", alarm_flag, 1'b0);
        chk("R1", "irq_pin", irq_pin, 1'b0);
        @(posedge clk); #1;
        rst_n = 1;
        step("R1");

        // R2: program alarm, sec/min compared, others masked
        wr(0, 8'h30, 1, "R2");
        wr(1, 8'h15, 1, "R2");
        wr(2, 8'h80, 1, "R2");
        wr(3, 8'h80, 1, "R2");
        wr(4, 8'h80, 1, "R2");
        // R2: out-of-range select changes nothing
        wr(5, 8'h00, 1, "R2");
        // R3: locked write ignored
        wr(0, 8'h45, 0, "R3");
        irq_en = 1; irq_pulse = 0; irq_act_high = 1;
        set_live(8'h45, 8'h15);
        tick("R3");
        chk("R3", "no alarm on locked value", alarm_flag, 1'b0);
        set_live(8'h30, 8'h15);
        // R5: no tick, no flag
        step("R5");
        chk("R5", "match without tick", alarm_flag, 1'b0);
        tick("R5");
        chk("R5", "flag set", alarm_flag, 1'b1);
        chk("R8", "level irq active", irq_pin, 1'b1);
        for (int k = 0; k < 10; k++) begin tick32 = 1; step("R8"); end
        chk("R8", "level irq held", irq_pin, 1'b1);
        rd("R6");
        chk("R6", "flag cleared", alarm_flag, 1'b0);
        chk("R8", "level irq released", irq_pin, 1'b0);

        // R4: minute compared and mismatched, then masked
        set_live(8'h30, 8'h16);
        tick("R4");
        chk("R4", "minute mismatch", alarm_flag, 1'b0);
        wr(1, 8'h95, 1, "R4");
        tick("R4");
        chk("R4", "minute masked", alarm_flag, 1'b1);

        // R6: read with simultaneous event keeps flag
        sec_tick = 1; flags_rd = 1; step("R6");
        chk("R6", "event wins over read", alarm_flag, 1'b1);
        rd("R6");

        // R7: interrupt disabled
        irq_en = 0;
        tick("R7");
        chk("R7", "flag without irq", alarm_flag, 1'b1);
        chk("R7", "irq stays idle", irq_pin, 1'b0);
        rd("R7");

        // R9: pulse timeout
        irq_en = 1; irq_pulse = 1;
        tick("R9");
        for (int k = 0; k < PT - 1; k++) begin tick32 = 1; step("R9"); end
        chk("R9", "pulse still active", irq_pin, 1'b1);
        tick32 = 1; step("R9");
        chk("R9", "pulse ended", irq_pin, 1'b0);
        chk("R9", "flag survives pulse end", alarm_flag, 1'b1);
        // R9: early read
        tick("R9");
        tick32 = 1; step("R9");
        rd("R9");
        chk("R9", "pulse cut by read", irq_pin, 1'b0);

        // R10: active-low polarity
        irq_act_high = 0; irq_pulse = 0;
        step("R10");
        chk("R10", "idle high", irq_pin, 1'b1);
        tick("R10");
        chk("R10", "active low", irq_pin, 1'b0);
        rd("R10");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            string rq;
            rq = "R5";
            irq_en = 1'($urandom_range(0, 3) != 0);
            irq_pulse = 1'($urandom_range(0, 1));
            irq_act_high = 1'($urandom_range(0, 1));
            for (int i = 0; i < NF; i++)
                live_f[i] = ($urandom_range(0, 1) == 1) ? {1'b0, regs_m[i][6:0]}
                                                         : 8'($urandom_range(0, 8'h59));
            if ($urandom_range(0, 9) == 0) begin
                reg_wr = 1; reg_sel = 3'($urandom_range(0, 7));
                reg_wdata = 8'($urandom_range(0, 255)) & 8'hBF;
                wr_unlock = 1'($urandom_range(0, 1));
                rq = wr_unlock ? "R2" : "R3";
            end
            sec_tick = 1'($urandom_range(0, 2) == 0);
            tick32 = 1'($urandom_range(0, 1));
            flags_rd = 1'($urandom_range(0, 7) == 0);
            if (flags_rd) rq = "R6";
            step(rq);
            wr_unlock = 0;
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule